// File: doc/BRIEF.md
# Phase-Accumulator Waveform Synthesizer

This block produces one sample of a periodic waveform per clock. A wide phase register advances by a programmable step on every enabled clock. The most significant bits of that register select an entry of a waveform table, and the entry becomes the output sample. The low bits of the register hold fractional phase. They let the output frequency move in steps of the clock rate divided by 2^ACC_W, instead of being limited to whole divisions of the clock.

The step value can change on any clock, which gives frequency modulation. A load strobe writes a new value straight into the phase register, which gives a phase jump or phase modulation. The table is filled through a plain write port.

Samples leave through a valid/ready stream. When `smp_valid` is high and `smp_ready` is low, the whole pipeline stalls: the sample and its valid flag hold, the phase register stops accumulating, and no sample is lost or repeated. Bubbles, meaning stage contents with valid low, are never stalled. A phase load is always taken, even during a stall. The control inputs are plain level and strobe signals.

Top module: `dds_synth`

## Requirements
- R1: After reset, `smp_valid` is 0 and the phase register is 0, so the first enabled sample is table entry 0.
- R2: On each advancing clock with `run_en` high and no load, the phase register becomes its old value plus `phase_step`. A step of 2^20 moves exactly one table entry per sample.
- R3: A step below 2^20 advances by a fraction of an entry. For example, 2^18 repeats each entry on four consecutive samples.
- R4: The phase register wraps modulo 2^32 with no saturation. With step 2^20, entry 4095 is followed by entry 0.
- R5: `phase_load` writes `phase_load_val` into the phase register at the next edge, even when `run_en` is high and even during a stall. Accumulation resumes from the loaded value on the following clock.
- R6: While `run_en` is low, the phase register holds its value and the samples that emerge carry `smp_valid` low.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid` and `smp_sample` hold on the next clock, and the phase register does not accumulate.
- R8: A new `phase_step` is used by the very next accumulation.
- R9: A table write with `tbl_we` high stores `tbl_wdata` at `tbl_waddr`. A later read of that entry returns it. A read of the same entry on the same edge returns the old contents.
- R10: The table entry addressed by the top 12 phase bits before an advancing edge appears on `smp_sample` two advancing edges later. Its valid flag equals `run_en` at the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Accumulate and emit valid samples |
| phase_step | input | 32 | Phase increment per sample |
| phase_load | input | 1 | Overwrite phase register strobe |
| phase_load_val | input | 32 | Value written by phase_load |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 12 | Table write address |
| tbl_wdata | input | 12 | Table write data |
| smp_valid | output | 1 | Output sample valid |
| smp_ready | input | 1 | Downstream accepts sample |
| smp_sample | output | 12 | Output waveform sample |

## Verification
The bench targets several corner cases. It checks the wrap from entry 4095 to entry 0. A design that saturated or flagged overflow would stick at the top entry there. It checks a load and an enable on the same clock. A design with the wrong priority would emit an entry one step past the loaded phase. Fractional steps are tested because they expose truncation taken from the wrong bits, which shows up as the wrong repeat count. Random back-pressure, including loads during a stall, catches a design that drops or repeats samples or keeps accumulating while stalled. Writes to an entry just before it is read catch a design with the wrong table-write ordering.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DDS_ACC_W  = 32;
  localparam int unsigned DDS_ADDR_W = 12;
  localparam int unsigned DDS_SAMP_W = 12;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W = dds_pkg::DDS_ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  input  logic             ld,
  input  logic [ACC_W-1:0] ld_val,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)         phase <= '0;
    else if (ld)        phase <= ld_val;
    else if (en && adv) phase <= phase + step;
  end

  AST_LOAD_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> phase == $past(ld_val)); // R5
  AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && en && adv) |=> phase == $past(phase) + $past(step)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(en && adv)) |=> $stable(phase)); // R6
endmodule

// File: rtl/dds_addr_stage.sv
module dds_addr_stage #(
  parameter int unsigned ACC_W  = dds_pkg::DDS_ACC_W,
  parameter int unsigned ADDR_W = dds_pkg::DDS_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              en,
  input  logic [ACC_W-1:0]  phase,
  output logic [ADDR_W-1:0] addr,
  output logic              vld
);
  localparam int unsigned FRAC_W = ACC_W - ADDR_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      vld  <= 1'b0;
    end else if (adv) begin
      addr <= phase[ACC_W-1:FRAC_W];
      vld  <= en;
    end
  end
endmodule

// File: rtl/dds_wave_table.sv
module dds_wave_table #(
  parameter int unsigned ADDR_W = dds_pkg::DDS_ADDR_W,
  parameter int unsigned SAMP_W = dds_pkg::DDS_SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [SAMP_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              rvld,
  output logic [SAMP_W-1:0] sample,
  output logic              vld
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample <= '0;
      vld    <= 1'b0;
    end else if (adv) begin
      sample <= mem[raddr];
      vld    <= rvld;
    end
  end
endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
  parameter int unsigned ACC_W  = dds_pkg::DDS_ACC_W,
  parameter int unsigned ADDR_W = dds_pkg::DDS_ADDR_W,
  parameter int unsigned SAMP_W = dds_pkg::DDS_SAMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ACC_W-1:0]  phase_step,
  input  logic              phase_load,
  input  logic [ACC_W-1:0]  phase_load_val,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_waddr,
  input  logic [SAMP_W-1:0] tbl_wdata,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SAMP_W-1:0] smp_sample
);
  logic              adv;
  logic [ACC_W-1:0]  phase;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_vld;

  assign adv = !smp_valid || smp_ready;

  dds_phase_acc #(.ACC_W(ACC_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .en(run_en), .step(phase_step),
    .ld(phase_load), .ld_val(phase_load_val), .phase(phase)
  );

  dds_addr_stage #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) i_addr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .en(run_en), .phase(phase),
    .addr(s1_addr), .vld(s1_vld)
  );

  dds_wave_table #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) i_tbl (
    .clk(clk), .rst_n(rst_n), .adv(adv), .we(tbl_we), .waddr(tbl_waddr),
    .wdata(tbl_wdata), .raddr(s1_addr), .rvld(s1_vld),
    .sample(smp_sample), .vld(smp_valid)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_sample))); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rst_n) |-> !smp_valid); // R1
endmodule

// File: tb/test_dds_synth.sv
module test_dds_synth;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] phase_step = '0;
  logic        phase_load = 1'b0;
  logic [31:0] phase_load_val = '0;
  logic        tbl_we = 1'b0;
  logic [11:0] tbl_waddr = '0;
  logic [11:0] tbl_wdata = '0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [11:0] smp_sample;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R1";

  always #2 clk = ~clk;

  dds_synth i_dds_synth (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_step(phase_step),
    .phase_load(phase_load), .phase_load_val(phase_load_val),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_sample(smp_sample)
  );

  function automatic logic [11:0] pat(int i);
    return 12'((i * 37 + 5) & 32'hFFF);
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // behavioural reference model
  logic [11:0] m_tab [4096];
  logic [31:0] m_acc;
  logic        m_v1, m_vo;
  logic [11:0] m_d1, m_do;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_v1 = 0; m_vo = 0; m_d1 = 0; m_do = 0;
    end else begin
      bit go;
      go = !m_vo || smp_ready;
      if (go) begin
        m_vo = m_v1; m_do = m_d1;
        m_v1 = run_en; m_d1 = m_tab[m_acc[31:20]];
      end
      if (phase_load) m_acc = phase_load_val;
      else if (run_en && go) m_acc = m_acc + phase_step;
    end
    if (tbl_we) m_tab[tbl_waddr] = tbl_wdata;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({req, " valid"}, int'(smp_valid), int'(m_vo));
      if (m_vo) chk({req, " sample"}, int'(smp_sample), int'(m_do));
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // fill the table while in reset (writes are not gated by reset)
    for (int i = 0; i < 4096; i++) begin
      tbl_we = 1; tbl_waddr = 12'(i); tbl_wdata = pat(i);
      @(negedge clk);
    end
    tbl_we = 0;
    rst_n = 1;
    @(negedge clk);
    req = "R1";
    chk("R1 reset valid", int'(smp_valid), 0);
    // R1/R10: first enabled sample is entry 0, two edges after enabling
    run_en = 1; phase_step = 32'h0010_0000;
    @(negedge clk);
    chk("R10 not yet valid", int'(smp_valid), 0);
    @(negedge clk);
    chk("R10 valid after two edges", int'(smp_valid), 1);
    chk("R1 first sample entry0", int'(smp_sample), int'(pat(0)));
    req = "R2";
    @(negedge clk);
    chk("R2 next entry", int'(smp_sample), int'(pat(1)));
    repeat (20) @(negedge clk);
    // R3 fractional step
    req = "R3";
    phase_load = 1; phase_load_val = 32'h0050_0000; phase_step = 32'h0004_0000;
    @(negedge clk);
    phase_load = 0;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R3 repeat entry5", int'(smp_sample), int'(pat(5)));
      @(negedge clk);
    end
    chk("R3 then entry6", int'(smp_sample), int'(pat(6)));
    repeat (10) @(negedge clk);
    // R4 wrap and R5 load with enable
    req = "R4";
    phase_load = 1; phase_load_val = 32'hFFF0_0000; phase_step = 32'h0010_0000;
    @(negedge clk);
    phase_load = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 loaded entry4095", int'(smp_sample), int'(pat(4095)));
    @(negedge clk);
    chk("R4 wrap to entry0", int'(smp_sample), int'(pat(0)));
    req = "R5";
    repeat (5) @(negedge clk);
    // R8 step change mid-run
    req = "R8";
    for (int k = 0; k < 30; k++) begin
      phase_step = 32'h0001_0000 * (k % 7 + 1) + 32'(k * 4099);
      @(negedge clk);
    end
    // R6 enable low
    req = "R6";
    run_en = 0;
    repeat (3) @(negedge clk);
    chk("R6 valid low", int'(smp_valid), 0);
    repeat (5) @(negedge clk);
    run_en = 1;
    repeat (10) @(negedge clk);
    // R7 back-pressure with loads during stalls
    req = "R7";
    for (int k = 0; k < 300; k++) begin
      smp_ready = (k % 3) != 0;
      phase_load = (k % 17) == 5;
      phase_load_val = 32'(k) * 32'h0123_4567;
      run_en = (k % 11) != 4;
      phase_step = 32'h0003_0000 + 32'(k * 977);
      @(negedge clk);
    end
    smp_ready = 0; phase_load = 0; run_en = 1;
    @(negedge clk);
    begin
      logic [11:0] held;
      held = smp_sample;
      @(negedge clk);
      chk("R7 stalled sample holds", int'(smp_sample), int'(held));
      chk("R7 stalled valid holds", int'(smp_valid), 1);
    end
    smp_ready = 1;
    repeat (5) @(negedge clk);
    // R9 table writes including same-edge read
    req = "R9";
    phase_load = 1; phase_load_val = 32'h0200_0000; phase_step = 32'h0010_0000;
    @(negedge clk);
    phase_load = 0;
    tbl_we = 1; tbl_waddr = 12'h021; tbl_wdata = 12'hABC;
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 12'h022; tbl_wdata = 12'h5A5;
    @(negedge clk);
    tbl_we = 0;
    repeat (6) @(negedge clk);
    phase_load = 1; phase_load_val = 32'h0210_0000;
    @(negedge clk);
    phase_load = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 written entry 0x21", int'(smp_sample), 12'hABC);
    @(negedge clk);
    chk("R9 written entry 0x22", int'(smp_sample), 12'h5A5);
    repeat (5) @(negedge clk);
    // R1 reset mid-run
    req = "R1";
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 valid cleared by reset", int'(smp_valid), 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule